// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic/logic stage of a small 8-bit processor core. Each cycle it takes two byte operands and a 4-bit operation code and produces a byte result and the next values of four status flags. It combines these with the flags it currently holds. The operations are add, add with carry-in, subtract, subtract with borrow-in, AND, OR, XOR, and rotate left or right through the carry flag. Result and next flags are combinational. The flags are committed to an internal status register on the clock edge when `op_valid` is high.

The status register is also exposed on a byte-wide register port. Software can read it at any time and overwrite it with `reg_wr_en`. The four flags occupy the low nibble. The high nibble is reserved. For subtraction, carry and auxiliary carry report that a borrow occurred. Carry is not inverted.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the status register clears, so `reg_rd_data` reads 0x00 after that edge.
- R2: `reg_rd_data` is {4'b0000, OV, AC, C, Z}, with OV at bit 3, AC at bit 2, C at bit 1 and Z at bit 0. The reserved bits 7..4 always read 0, and values written to them are dropped.
- R3: When `reg_wr_en` is high at a clock edge, the flags load `reg_wr_data[3:0]`. This takes priority over an ALU update in the same cycle.
- R4: When `op_valid` is high and `reg_wr_en` is low at a clock edge, the flags load `flag_next`. When both are low, the flags hold.
- R5: ADD (code 0) and ADC (code 1) give result = a + b (+ C for ADC) mod 256. C is set on a carry out of bit 7, and AC is set on a carry out of bit 3.
- R6: SUB (code 2) and SBC (code 3) give result = a − b (− C for SBC) mod 256. C is set when the full subtraction borrows, and AC is set when the low nibble borrows from the high nibble.
- R7: For the four add/subtract codes, OV is set exactly when the two's-complement result is outside −128..127.
- R8: For every defined code (0..8), Z is set when the result is 0x00 and cleared otherwise.
- R9: AND (4), OR (5) and XOR (6) apply the bitwise function to a and b. They change only Z, and keep OV, AC and C.
- R10: RLC (7) gives {a[6:0], C} and loads C with a[7]. RRC (8) gives {C, a[7:1]} and loads C with a[0]. Both keep OV and AC.
- R11: Codes 9..15 pass a to the result, and `flag_next` equals the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit flag_next to the status register at this edge |
| op_code | input | 4 | Operation select |
| opnd_a | input | 8 | First operand (the rotate source) |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| flag_next | output | 4 | Combinational next flags {OV,AC,C,Z} |
| reg_wr_en | input | 1 | Direct write of the status register |
| reg_wr_data | input | 8 | Write data; bits 3..0 used |
| reg_rd_data | output | 8 | Status register read value |

## Verification
`result` and `flag_next` are combinational and due in the same cycle as the operands. The bench drives the operands on a falling edge and compares these outputs one nanosecond later, using the flags held at that moment. Register effects (R1–R4) appear one edge later. Each of them is sampled one nanosecond after the following rising edge, before the next stimulus. A bench-side reference model tracks the expected flag register across operations, so that carry-in and borrow-in cases use the flags left by earlier steps.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 4;
    localparam int REG_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_RLC = 4'd7,
        OP_RRC = 4'd8
    } op_e;

    // Bit order matches the register layout: ov=3, ac=2, cy=1, zr=0
    typedef struct packed {
        logic ov;
        logic ac;
        logic cy;
        logic zr;
    } flags_t;

    typedef logic [DATA_W-1:0] word_t;

    function automatic logic is_arith(input logic [OP_W-1:0] code);
        return code <= OP_SBC;
    endfunction

    function automatic logic is_defined(input logic [OP_W-1:0] code);
        return code <= OP_RRC;
    endfunction

    function automatic logic zero_of(input word_t v);
        return v == '0;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_e    op,
    input  word_t  a,
    input  word_t  b,
    input  flags_t cur,
    output word_t  res,
    output flags_t flg
);
    localparam int WIDE_W = DATA_W + 1;
    localparam int NWID_W = NIB_W + 1;

    logic              sub_mode;
    logic              cin;
    logic [WIDE_W-1:0] full;
    logic [NWID_W-1:0] low;
    logic              sgn_ov;

    always_comb begin
        sub_mode = (op == OP_SUB) || (op == OP_SBC);
        cin      = ((op == OP_ADC) || (op == OP_SBC)) ? cur.cy : 1'b0;
        if (sub_mode) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
            sgn_ov = (a[DATA_W-1] != b[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
            sgn_ov = (a[DATA_W-1] == b[DATA_W-1]) && (full[DATA_W-1] != a[DATA_W-1]);
        end
        res    = full[DATA_W-1:0];
        flg.cy = full[DATA_W];
        flg.ac = low[NIB_W];
        flg.ov = sgn_ov;
        flg.zr = zero_of(full[DATA_W-1:0]);
    end

    // R5
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD) |-> (res == word_t'(a + b)) && (flg.cy == (res < a)));

    // R6
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB) |-> (res == word_t'(a - b)) && (flg.cy == (a < b)));

    // R7
    add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD) |-> flg.ov == ((a[7] & b[7] & ~res[7]) | (~a[7] & ~b[7] & res[7])));

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_e    op,
    input  word_t  a,
    input  word_t  b,
    input  flags_t cur,
    output word_t  res,
    output flags_t flg
);
    always_comb begin
        flg = cur;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_RLC: begin
                res    = {a[DATA_W-2:0], cur.cy};
                flg.cy = a[DATA_W-1];
            end
            OP_RRC: begin
                res    = {cur.cy, a[DATA_W-1:1]};
                flg.cy = a[0];
            end
            default: res = a;
        endcase
        flg.zr = zero_of(res);
    end

    // R9
    logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_AND || op == OP_OR || op == OP_XOR)
            |-> {flg.ov, flg.ac, flg.cy} == {cur.ov, cur.ac, cur.cy});

    // R10
    rot_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RLC) |-> (flg.cy == a[7]) && (res[0] == cur.cy) && (flg.ov == cur.ov));

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  flags_t            upd_val,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_val,
    output flags_t            q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= flags_t'(wr_val);
        else if (upd)   q <= upd_val;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R3
    write_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == flags_t'($past(wr_val))));

    // R4
    update_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !wr_en) |=> (q == $past(upd_val)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd && !wr_en) |=> $stable(q));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [7:0]  opnd_a,
    input  logic [7:0]  opnd_b,
    output logic [7:0]  result,
    output logic [3:0]  flag_next,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  reg_rd_data
);
    localparam int RSV_W = REG_W - FLAG_W;

    op_e    op;
    flags_t cur_flags;
    flags_t ar_flg;
    flags_t bo_flg;
    flags_t nxt_flg;
    word_t  ar_res;
    word_t  bo_res;
    logic   unused_rsv;

    assign op         = op_e'(op_code);
    assign unused_rsv = ^reg_wr_data[REG_W-1:FLAG_W];

    alu8_arith u_arith (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .cur (cur_flags),
        .res (ar_res),
        .flg (ar_flg)
    );

    alu8_bitops u_bitops (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .cur (cur_flags),
        .res (bo_res),
        .flg (bo_flg)
    );

    always_comb begin
        if (!is_defined(op_code)) begin
            result  = opnd_a;
            nxt_flg = cur_flags;
        end else if (is_arith(op_code)) begin
            result  = ar_res;
            nxt_flg = ar_flg;
        end else begin
            result  = bo_res;
            nxt_flg = bo_flg;
        end
    end

    assign flag_next = nxt_flg;

    alu8_flagreg u_flagreg (
        .clk     (clk),
        .rst     (rst),
        .upd     (op_valid),
        .upd_val (nxt_flg),
        .wr_en   (reg_wr_en),
        .wr_val  (reg_wr_data[FLAG_W-1:0]),
        .q       (cur_flags)
    );

    assign reg_rd_data = {{RSV_W{1'b0}}, cur_flags};

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        is_defined(op_code) |-> (flag_next[0] == (result == 8'h00)));

    // R11
    undef_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !is_defined(op_code) |-> (result == opnd_a) && (flag_next == reg_rd_data[3:0]));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> (reg_rd_data[7:4] == 4'h0) && (reg_rd_data[3:0] == $past(reg_wr_data[3:0])));

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] result;
    logic [3:0] flag_next;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'd0;
    logic [7:0] reg_rd_data;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_f = 4'h0;   // {OV,AC,C,Z}

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .flag_next(flag_next),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model from the requirements; returns {result, OV, AC, C, Z}
    function automatic logic [11:0] model(input int op, input int a, input int b, input logic [3:0] f);
        int r, c, sa, sb, t;
        logic ov, ac, cy;
        ov = f[3]; ac = f[2]; cy = f[1];
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        c = 0;
        if (op == 1 || op == 3) c = int'(f[1]);
        case (op)
            0, 1: begin
                t = a + b + c; r = t % 256; cy = t > 255;
                ac = ((a % 16) + (b % 16) + c) > 15;
                ov = (sa + sb + c > 127) || (sa + sb + c < -128);
            end
            2, 3: begin
                t = a - b - c; r = (t + 512) % 256; cy = t < 0;
                ac = ((a % 16) - (b % 16) - c) < 0;
                ov = (sa - sb - c > 127) || (sa - sb - c < -128);
            end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: begin r = ((a * 2) % 256) + int'(f[1]); cy = a > 127; end
            8: begin r = (a / 2) + 128 * int'(f[1]); cy = (a % 2) == 1; end
            default: return {8'(a), f};
        endcase
        return {8'(r), ov, ac, cy, (r == 0)};
    endfunction

    task automatic do_op(input int op, input int a, input int b, input string req);
        logic [11:0] e;
        @(negedge clk);
        op_code = 4'(op); opnd_a = 8'(a); opnd_b = 8'(b); op_valid = 1'b1;
        e = model(op, a, b, model_f);
        #1;
        check(result == e[11:4], req, result, e[11:4]);
        check(flag_next == e[3:0], req, flag_next, e[3:0]);
        @(posedge clk); #1;
        op_valid = 1'b0;
        model_f = e[3:0];
        check(reg_rd_data == {4'h0, model_f}, "R4", reg_rd_data, {4'h0, model_f});
    endtask

    task automatic write_flags(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        model_f = d[3:0];
        check(reg_rd_data == {4'h0, d[3:0]}, "R2", reg_rd_data, {4'h0, d[3:0]});
    endtask

    task automatic t_reset();
        write_flags(8'h0F);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check(reg_rd_data == 8'h00, "R1", reg_rd_data, 0);
        @(negedge clk); rst = 1'b0;
        model_f = 4'h0;
    endtask

    task automatic t_add();
        do_op(0, 8'h12, 8'h34, "R5");
        do_op(0, 8'h7F, 8'h01, "R7");   // OV and AC
        do_op(0, 8'hFF, 8'h01, "R8");   // zero, C, AC
        do_op(1, 8'h10, 8'h20, "R5");   // ADC with C=1 from previous
        do_op(0, 8'h80, 8'h80, "R7");   // negative overflow, zero
    endtask

    task automatic t_sub();
        write_flags(8'h00);
        do_op(2, 8'h00, 8'h01, "R6");   // full borrow
        do_op(3, 8'h20, 8'h10, "R6");   // SBC with borrow-in
        do_op(2, 8'h80, 8'h01, "R7");
        do_op(2, 8'h10, 8'h01, "R6");   // nibble borrow only
        do_op(2, 8'h55, 8'h55, "R8");
        do_op(3, 8'h00, 8'h00, "R6");   // borrow-in = 0 here
    endtask

    task automatic t_logic();
        write_flags(8'hFE);             // OV,AC,C set; upper bits dropped
        do_op(4, 8'h0F, 8'hF0, "R9");
        do_op(5, 8'h0F, 8'hF0, "R9");
        do_op(6, 8'hAA, 8'hAA, "R9");
        write_flags(8'h00);
        do_op(6, 8'h3C, 8'h0F, "R9");
    endtask

    task automatic t_rotate();
        write_flags(8'h0C);             // OV, AC set, C clear
        do_op(7, 8'h81, 8'h00, "R10");
        do_op(7, 8'h00, 8'h00, "R10");  // rotates in C=1
        do_op(8, 8'h01, 8'h00, "R10");
        do_op(8, 8'h00, 8'h00, "R10");  // rotates in C=1 at bit 7
        write_flags(8'h00);
        do_op(7, 8'h80, 8'h00, "R8");   // zero result
    endtask

    task automatic t_regport();
        write_flags(8'hF0);
        check(reg_rd_data == 8'h00, "R2", reg_rd_data, 0);
        write_flags(8'h05);
        @(negedge clk);
        op_code = 4'd0; opnd_a = 8'hFF; opnd_b = 8'h01; op_valid = 1'b1;
        reg_wr_en = 1'b1; reg_wr_data = 8'h0A;
        @(posedge clk); #1;
        op_valid = 1'b0; reg_wr_en = 1'b0;
        model_f = 4'hA;
        check(reg_rd_data == 8'h0A, "R3", reg_rd_data, 8'h0A);
        @(negedge clk);
        op_code = 4'd0; opnd_a = 8'hFF; opnd_b = 8'hFF;
        @(posedge clk); #1;
        check(reg_rd_data == 8'h0A, "R4", reg_rd_data, 8'h0A);
    endtask

    task automatic t_undef();
        write_flags(8'h06);
        for (int k = 9; k < 16; k++) do_op(k, 8'h00 + k * 3, 8'h5A, "R11");
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check(reg_rd_data == 8'h00, "R1", reg_rd_data, 0);
        @(negedge clk); rst = 1'b0;
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_regport();
        t_undef();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule